// File: doc/BRIEF.md
# Write-Protected Configuration Register Bank

This block holds a small bank of configuration words (per-master settings, per-slave settings, per-slave arbitration priorities, one system I/O word and one general scratch word) behind a single register request/response channel. A mode register carries a protection switch. While protection is on, any write aimed at the master, slave, priority or system I/O words is dropped without touching the stored value, and the attempt is logged in a status register. The log is a sticky flag plus the word offset of the last blocked target.

Software reads the status register to learn that a blocked write happened. The read returns the flag as it was and clears it in the same step. The offset field stays until the next violation overwrites it. The mode register and the scratch word can be written at any time, so protection can always be turned off again.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every request, read or write, yields exactly one response on the following cycle. `req_ready` is low while a response is waiting and `rsp_ready` is low. A response that is held back keeps `rsp_valid` high and `rsp_rdata` unchanged until it is taken.

Top module: `wpcb_top`

## Requirements
- R1: After reset every configuration word reads 0, the mode register reads 0 (protection off) and the status register reads 0.
- R2: With protection off, a write to any master (word offsets 0 to 3), slave (8 to 11), priority (16 to 19) or system I/O (24) word stores the write data, and a later read returns it.
- R3: With protection on (mode register at offset 32, bit 0 set), a write to a master, slave, priority or system I/O word leaves that word unchanged.
- R4: A blocked write sets the violation flag (status register at offset 33, bit 0) on the clock edge after the one that accepted the write. The flag stays set until it is cleared as described in R6.
- R5: On each violation the source field (status bits 13:8) takes the word offset of the blocked target, replacing any earlier value.
- R6: A read of the status register returns the flag value from before the read and clears the flag. The source field is kept.
- R7: If a violation is being recorded on the same edge that accepts a status read, the flag stays set and the source field takes the new offset. The read itself returns the older flag and source.
- R8: The mode register and the unprotected scratch word (offset 28) take writes whether protection is on or off. Mode bit 0 reads back as written, and its other bits read 0.
- R9: A request is accepted only when `req_valid` and `req_ready` are both high. Each accepted request produces one response on the next cycle, with read data for reads and 0 for writes. While a response is held back by `rsp_ready`, `req_ready` is low and `rsp_rdata` stays stable.
- R10: Reads of unmapped offsets return 0. Writes to unmapped offsets or to the status register change no stored value and record no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word offset of the target register |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | DATA_W | Read data (0 for writes) |

## Verification
The bench places a status read directly behind a blocked write, so that recording the violation and clearing the flag fall on the same edge. A design that let the clear win would lose the violation, and one that did not delay its update would return the new source too early. Two violations in a row check that the source field is overwritten and not kept from the first one. A blocked write must also be shown to leave the stored word alone, and to leave the mode and scratch words writable, because a design that gated every write on protection could never be unlocked. Holding `rsp_ready` low checks that the held response stays stable and that `req_ready` drops; a design that ignored back-pressure would accept a new request and lose a response.

// File: rtl/wpcb_pkg.sv
package wpcb_pkg;
  // word offsets of the register groups
  localparam int MST_BASE = 0;
  localparam int SLV_BASE = 8;
  localparam int PRI_BASE = 16;
  localparam int SIO_OFF  = 24;
  localparam int SCR_OFF  = 28;
  localparam int MODE_OFF = 32;
  localparam int STAT_OFF = 33;
  // status word layout
  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_SRC_LSB  = 8;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CFG  = 2'd1,
    RD_MODE = 2'd2,
    RD_STAT = 2'd3
  } rd_src_e;
endpackage

// File: rtl/wpcb_decode.sv
module wpcb_decode
  import wpcb_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int NUM_MST = 4,
  parameter int NUM_SLV = 4,
  localparam int NUM_CFG = NUM_MST + 2 * NUM_SLV + 2
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_CFG-1:0] hit,
  output logic               is_prot,
  output rd_src_e            rd_src
);
  logic [NUM_CFG-1:0] prot_v;

  // one comparator per storage word; the last word is the scratch word
  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cmp
    localparam int OFF =
      (i < NUM_MST)               ? MST_BASE + i :
      (i < NUM_MST + NUM_SLV)     ? SLV_BASE + (i - NUM_MST) :
      (i < NUM_MST + 2 * NUM_SLV) ? PRI_BASE + (i - NUM_MST - NUM_SLV) :
      (i == NUM_MST + 2 * NUM_SLV) ? SIO_OFF : SCR_OFF;
    localparam bit PROT = (i != NUM_CFG - 1);
    assign hit[i]    = (addr == ADDR_W'(OFF));
    assign prot_v[i] = hit[i] & PROT;
  end

  assign is_prot = |prot_v;

  always_comb begin
    if (|hit)                              rd_src = RD_CFG;
    else if (addr == ADDR_W'(MODE_OFF))    rd_src = RD_MODE;
    else if (addr == ADDR_W'(STAT_OFF))    rd_src = RD_STAT;
    else                                   rd_src = RD_NONE;
  end
endmodule

// File: rtl/wpcb_store.sv
module wpcb_store #(
  parameter int DATA_W  = 32,
  parameter int NUM_CFG = 14
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_ok,
  input  logic [NUM_CFG-1:0]              hit,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NUM_CFG-1:0][DATA_W-1:0]  cfg_q,
  output logic [DATA_W-1:0]               rd_word
);
  for (genvar i = 0; i < NUM_CFG; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cfg_q[i] <= '0;
      else if (wr_ok && hit[i])  cfg_q[i] <= wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (hit[i]) rd_word = rd_word | cfg_q[i];
  end
endmodule

// File: rtl/wpcb_status.sv
module wpcb_status #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blocked,
  input  logic [ADDR_W-1:0] blocked_addr,
  input  logic              stat_rd,
  output logic              flag,
  output logic [ADDR_W-1:0] src
);
  // violation is staged one cycle before it lands in the status register
  logic              viol_q;
  logic [ADDR_W-1:0] viol_src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q     <= 1'b0;
      viol_src_q <= '0;
    end else begin
      viol_q     <= blocked;
      viol_src_q <= blocked ? blocked_addr : viol_src_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      src  <= '0;
    end else if (viol_q) begin
      flag <= 1'b1;
      src  <= viol_src_q;
    end else if (stat_rd) begin
      flag <= 1'b0;
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |=> flag); // R4
  AST_SRC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |=> (src == $past(viol_src_q))); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !viol_q) |=> !flag); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && viol_q) |=> flag); // R7
  AST_SRC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_q |=> $stable(src)); // R6
endmodule

// File: rtl/wpcb_top.sv
module wpcb_top
  import wpcb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6,
  parameter int NUM_MST = 4,
  parameter int NUM_SLV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int NUM_CFG = NUM_MST + 2 * NUM_SLV + 2;

  logic                           accept, wr, rd, blocked, wr_ok, stat_rd;
  logic                           wp_en, flag;
  logic [ADDR_W-1:0]              src;
  logic [NUM_CFG-1:0]             hit;
  logic                           is_prot;
  rd_src_e                        rd_src;
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0]              cfg_word, rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr        = accept && req_write;
  assign rd        = accept && !req_write;

  wpcb_decode #(.ADDR_W(ADDR_W), .NUM_MST(NUM_MST), .NUM_SLV(NUM_SLV)) u_dec (
    .addr(req_addr), .hit(hit), .is_prot(is_prot), .rd_src(rd_src)
  );

  assign blocked = wr && is_prot && wp_en;
  assign wr_ok   = wr && !blocked;
  assign stat_rd = rd && (rd_src == RD_STAT);

  wpcb_store #(.DATA_W(DATA_W), .NUM_CFG(NUM_CFG)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .hit(hit),
    .wdata(req_wdata), .cfg_q(cfg_q), .rd_word(cfg_word)
  );

  wpcb_status #(.ADDR_W(ADDR_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .blocked(blocked), .blocked_addr(req_addr),
    .stat_rd(stat_rd), .flag(flag), .src(src)
  );

  // protection switch: never itself protected
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              wp_en <= 1'b0;
    else if (wr && rd_src == RD_MODE)        wp_en <= req_wdata[0];
  end

  always_comb begin
    rd_mux = '0;
    unique case (rd_src)
      RD_CFG:  rd_mux = cfg_word;
      RD_MODE: rd_mux[0] = wp_en;
      RD_STAT: begin
        rd_mux[STAT_FLAG_BIT]          = flag;
        rd_mux[STAT_SRC_LSB +: ADDR_W] = src;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd ? rd_mux : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_chk
    AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked && hit[i]) |=> $stable(cfg_q[i])); // R3
    AST_OPEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit[i] && !wp_en) |=> (cfg_q[i] == $past(req_wdata))); // R2
  end

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rd_src == RD_MODE) |=> (wp_en == $past(req_wdata[0]))); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R9
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R9
endmodule

// File: tb/wpcb_top_tb.sv
module wpcb_top_tb;
  localparam int CLK_NS = 20;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam logic [AW-1:0] MODE = 6'd32, STAT = 6'd33, SCR = 6'd28, SIO = 6'd24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  wpcb_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] stat_word(input bit f, input logic [AW-1:0] s);
    stat_word = '0;
    stat_word[0] = f;
    stat_word[8 +: AW] = s;
  endfunction

  // drive at a falling edge, returns at the falling edge after acceptance
  task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] r);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    forever begin
      if (req_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_valid ? rsp_rdata : 'x;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] r;
    xfer(1'b1, a, d, r);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] r);
    xfer(1'b0, a, '0, r);
  endtask

  task automatic t_reset();
    logic [DW-1:0] r;
    foreach (u_list[i]) begin
      rd(u_list[i], r); check("R1 cfg word after reset", r, '0);
    end
    rd(MODE, r); check("R1 mode after reset", r, '0);
    rd(STAT, r); check("R1 status after reset", r, '0);
  endtask

  logic [AW-1:0] u_list [10] = '{6'd0, 6'd3, 6'd8, 6'd11, 6'd16, 6'd19, 6'd24, 6'd28, 6'd1, 6'd9};

  task automatic t_open_writes();
    logic [DW-1:0] r;
    foreach (u_list[i]) wr(u_list[i], 32'hA500_0000 + 32'(i));
    foreach (u_list[i]) begin
      rd(u_list[i], r); check("R2 write with protection off", r, 32'hA500_0000 + 32'(i));
    end
    rd(STAT, r); check("R2 no violation when off", r, '0);
  endtask

  task automatic t_block();
    logic [DW-1:0] r;
    wr(MODE, 32'hFFFF_FFFF);
    rd(MODE, r); check("R8 mode reads bit0 only", r, 32'h1);
    wr(6'd3, 32'h1234_5678);
    rd(6'd3, r); check("R3 blocked master write keeps value", r, 32'hA500_0001);
    rd(STAT, r); check("R4 R5 flag and source set", r, stat_word(1'b1, 6'd3));
    rd(STAT, r); check("R6 flag cleared by read, source kept", r, stat_word(1'b0, 6'd3));
    wr(SIO, 32'hDEAD_BEEF);
    rd(SIO, r); check("R3 blocked sysio write keeps value", r, 32'hA500_0006);
    rd(STAT, r); check("R5 source is sysio", r, stat_word(1'b1, SIO));
    wr(SCR, 32'h0BAD_F00D);
    rd(SCR, r); check("R8 scratch writable when protected", r, 32'h0BAD_F00D);
    rd(STAT, r); check("R8 scratch write no violation", r, stat_word(1'b0, SIO));
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] r;
    wr(6'd10, 32'h1);               // blocked slave write
    rd(SCR, r);                     // gap so it lands
    wr(6'd19, 32'h2);               // blocked priority write
    rd(STAT, r); check("R7 read beside new violation returns older state", r, stat_word(1'b1, 6'd10));
    rd(STAT, r); check("R7 flag survives clear, source overwritten", r, stat_word(1'b1, 6'd19));
    rd(STAT, r); check("R6 flag now cleared", r, stat_word(1'b0, 6'd19));
    rd(6'd19, r); check("R3 blocked priority write keeps value", r, 32'hA500_0005);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] r;
    wr(6'd63, 32'hFFFF_FFFF);
    wr(STAT, 32'hFFFF_FFFF);
    rd(6'd63, r); check("R10 unmapped read returns zero", r, '0);
    rd(STAT, r); check("R10 unmapped and status writes no effect", r, stat_word(1'b0, 6'd19));
    wr(MODE, 32'h0);
    wr(6'd3, 32'hCAFE_0003);
    rd(6'd3, r); check("R8 unlock then master write lands", r, 32'hCAFE_0003);
  endtask

  task automatic t_backpressure();
    logic [DW-1:0] held;
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'd3;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check("R9 response present", 32'(rsp_valid), 32'h1);
    check("R9 ready low while held", 32'(req_ready), 32'h0);
    held = rsp_rdata;
    check("R9 held read data", held, 32'hCAFE_0003);
    req_valid = 1'b1; req_addr = SCR;      // must not be taken
    repeat (3) @(negedge clk);
    check("R9 data stable under back-pressure", rsp_rdata, held);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 response released", 32'(rsp_valid), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_open_writes();
    t_block();
    t_same_cycle();
    t_unmapped();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule